// File: doc/BRIEF.md
# Slave-Select Aware Interrupt Status Controller

This block gathers the event sources of a serial slave peripheral into one interrupt status register and drives a single level-sensitive interrupt line towards the processor. The sources are six level/pulse inputs from the FIFOs and transfer engines, plus the falling and the rising edge of the slave-select line. Each status bit is sticky. Once a source fires, the bit stays set until software clears it by writing a 1 to it.

Software masks each status bit with a per-bit enable register. A separate global enable register must also be set before anything reaches the interrupt pin. The slave-select input comes from another clock domain. It passes through a synchronizer chain (two flops by default). A two-state machine then tracks the line: the state `SS_DESEL` means the line is high and the slave is not selected, and `SS_SEL` means the line is low and the slave is selected. There are two transitions. `SS_DESEL -> SS_SEL` is taken when the synchronized line is low, and it emits a one-cycle falling-edge event. `SS_SEL -> SS_DESEL` is taken when the synchronized line is high, and it emits a one-cycle rising-edge event. Otherwise the machine stays in its state and emits nothing.

Software reaches the registers through a simple word port. Reads are combinational. Writes take effect at the clock edge where `reg_wr` is high.

Top module: `ssirq_ctrl`

## Requirements
- R1: After reset, the status, enable and global-enable registers read 0 and `irq` is low.
- R2: Event input `src_evt` sets status bits as follows: bit 0 sets bit 31 (TX programmable-empty), bit 1 sets bit 29 (TX empty), bit 2 sets bit 28 (RX programmable-full), bit 3 sets bit 27 (RX full), bit 4 sets bit 24 (TX DMA done) and bit 5 sets bit 23 (RX DMA done). A bit is set at the clock edge where its input is sampled high, and it stays set after the input drops.
- R3: `ss_n` passes through the synchronizer. A falling edge sets status bit 26 at the third rising clock edge after `ss_n` goes low, and not earlier. A rising edge sets status bit 25 with the same latency.
- R4: A write to address 0 (status) clears every status bit written with 1. Bits written with 0 keep their value.
- R5: If a source sets a bit in the same cycle that a write of 1 clears it, the bit ends up set.
- R6: Address 1 (enable) stores the written data at bits 31 and 29 to 23. All other enable bits read 0.
- R7: Address 2 (global enable) stores bit 0 of the write data. Its other bits read 0.
- R8: `irq` is high exactly when the global enable is 1 and at least one bit is set in both status and enable. It follows register contents combinationally.
- R9: Status bits other than 31 and 29 to 23 always read 0. Address 3 reads 0, and writes to it change no register.
- R10: Holding `ss_n` low produces only one falling-edge event. After bit 26 is cleared while the line stays low, it stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ss_n | input | 1 | Slave-select line, asynchronous, low = selected |
| src_evt | input | 6 | Event sources, mapped as in R2 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address: 0 status, 1 enable, 2 global enable, 3 reserved |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq | output | 1 | Level interrupt output |

## Verification
The event inputs are driven in three patterns: all six together, which checks the full bit mapping at once; a single source alone, which shows that mappings do not leak into other bits; and a source that coincides with a write-1 clear, which checks that a set wins over a clear. Clear writes are tried with a one-hot mask and with all zeros, so that clearing the right bit can be told apart from clearing everything and from clearing nothing. The slave-select line is sampled one cycle before and at the expected set cycle, which pins the synchronizer latency, and it is then held low after a clear to expose any repeated edge event. The interrupt pin is checked with the global enable off, with enable and status bits that do not overlap, and with overlapping bits, which separates the global gate from the per-bit mask.

// File: rtl/ssirq_pkg.sv
package ssirq_pkg;
    localparam int DW      = 32;
    localparam int NUM_SRC = 6;

    // status bit positions
    localparam int POS_TX_PEMPTY = 31;
    localparam int POS_TX_EMPTY  = 29;
    localparam int POS_RX_PFULL  = 28;
    localparam int POS_RX_FULL   = 27;
    localparam int POS_SS_FALL   = 26;
    localparam int POS_SS_RISE   = 25;
    localparam int POS_TX_DMA    = 24;
    localparam int POS_RX_DMA    = 23;

    localparam int SRC_POS [NUM_SRC] = '{POS_TX_PEMPTY, POS_TX_EMPTY, POS_RX_PFULL,
                                         POS_RX_FULL, POS_TX_DMA, POS_RX_DMA};

    localparam logic [DW-1:0] IRQ_MASK = 32'hBF80_0000;

    typedef enum logic [1:0] {
        A_STAT = 2'd0,
        A_EN   = 2'd1,
        A_GIE  = 2'd2,
        A_RSV  = 2'd3
    } reg_addr_t;

    typedef enum logic {
        SS_DESEL = 1'b0,
        SS_SEL   = 1'b1
    } ss_state_t;
endpackage

// File: rtl/ss_edge_detect.sv
module ss_edge_detect
    import ssirq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ss_n,
    output logic fall_evt,
    output logic rise_evt
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   ss_sync;
    ss_state_t              state_q;
    ss_state_t              state_d;

    // synchronizer chain, idles deselected (high)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], ss_n};
        end
    end

    assign ss_sync = sync_q[SYNC_STAGES-1];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SS_DESEL;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SS_DESEL: if (!ss_sync) state_d = SS_SEL;
            SS_SEL:   if (ss_sync)  state_d = SS_DESEL;
            default:  state_d = SS_DESEL;
        endcase
    end

    // outputs: one pulse per transition
    always_comb begin
        fall_evt = 1'b0;
        rise_evt = 1'b0;
        unique case (state_q)
            SS_DESEL: fall_evt = !ss_sync;
            SS_SEL:   rise_evt = ss_sync;
            default:  begin
                fall_evt = 1'b0;
                rise_evt = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int              W    = 32,
    parameter logic [W-1:0]    MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] stat_q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (MASK[i]) begin : g_live
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stat_q[i] <= 1'b0;
                end else begin
                    // set has priority over clear
                    stat_q[i] <= set_vec[i] | (stat_q[i] & ~clr_vec[i]);
                end
            end
        end else begin : g_rsv
            assign stat_q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/ssirq_ctrl.sv
module ssirq_ctrl
    import ssirq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ss_n,
    input  logic [NUM_SRC-1:0] src_evt,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [DW-1:0]      reg_wdata,
    output logic [DW-1:0]      reg_rdata,
    output logic               irq
);
    logic          ss_fall;
    logic          ss_rise;
    logic [DW-1:0] set_vec;
    logic [DW-1:0] clr_vec;
    logic [DW-1:0] stat_q;
    logic [DW-1:0] en_q;
    logic          gie_q;
    reg_addr_t     addr;

    assign addr = reg_addr_t'(reg_addr);

    ss_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_ss (
        .clk      (clk),
        .rst_n    (rst_n),
        .ss_n     (ss_n),
        .fall_evt (ss_fall),
        .rise_evt (ss_rise)
    );

    // route sources onto their status positions
    always_comb begin
        set_vec = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            set_vec[SRC_POS[s]] = src_evt[s];
        end
        set_vec[POS_SS_FALL] = ss_fall;
        set_vec[POS_SS_RISE] = ss_rise;
    end

    assign clr_vec = (reg_wr && addr == A_STAT) ? reg_wdata : '0;

    irq_status_bank #(.W(DW), .MASK(IRQ_MASK)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .stat_q  (stat_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            gie_q <= 1'b0;
        end else if (reg_wr) begin
            if (addr == A_EN)  en_q  <= reg_wdata & IRQ_MASK;
            if (addr == A_GIE) gie_q <= reg_wdata[0];
        end
    end

    always_comb begin
        unique case (addr)
            A_STAT:  reg_rdata = stat_q;
            A_EN:    reg_rdata = en_q;
            A_GIE:   reg_rdata = {{(DW-1){1'b0}}, gie_q};
            default: reg_rdata = '0;
        endcase
    end

    assign irq = gie_q & (|(stat_q & en_q));
endmodule

// File: rtl/ssirq_chk.sv
module ssirq_chk
    import ssirq_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic [1:0]    reg_addr,
    input logic [DW-1:0] stat_q,
    input logic [DW-1:0] en_q,
    input logic [DW-1:0] set_vec,
    input logic          gie_q,
    input logic          ss_fall,
    input logic          ss_rise,
    input logic          irq
);
    AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((stat_q & $past(set_vec)) == $past(set_vec))); // R5

    AST_CLEAR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == 2'd0) |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R4

    AST_RSV_STAT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q & ~IRQ_MASK) == '0); // R9

    AST_RSV_EN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q & ~IRQ_MASK) == '0); // R6

    AST_SS_ONE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ss_fall, ss_rise})); // R3

    AST_NO_REPEAT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        ss_fall |=> !ss_fall); // R10

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (gie_q && (stat_q & en_q) != '0)); // R8
endmodule

bind ssirq_ctrl ssirq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .stat_q   (stat_q),
    .en_q     (en_q),
    .set_vec  (set_vec),
    .gie_q    (gie_q),
    .ss_fall  (ss_fall),
    .ss_rise  (ss_rise),
    .irq      (irq)
);

// File: tb/sim_ssirq_ctrl.sv
module sim_ssirq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ss_n = 1'b1;
    logic [5:0]  src_evt = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ssirq_ctrl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .ss_n      (ss_n),
        .src_evt   (src_evt),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic pulse_src(input logic [5:0] m);
        @(negedge clk);
        src_evt = m;
        @(negedge clk);
        src_evt = '0;
    endtask

    task automatic t_reset;
        rd_chk(2'd0, 32'h0, "R1 status");
        rd_chk(2'd1, 32'h0, "R1 enable");
        rd_chk(2'd2, 32'h0, "R1 gie");
        check("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_reserved;
        wr(2'd3, 32'hFFFF_FFFF);
        rd_chk(2'd3, 32'h0, "R9 addr3 read");
        rd_chk(2'd1, 32'h0, "R9 addr3 write ignored enable");
        rd_chk(2'd2, 32'h0, "R9 addr3 write ignored gie");
    endtask

    task automatic t_sources;
        pulse_src(6'b111111);
        rd_chk(2'd0, 32'hB980_0000, "R2 all sources");
        check("R8 irq masked", {31'b0, irq}, 32'h0);
        wr(2'd0, 32'h8000_0000);
        rd_chk(2'd0, 32'h3980_0000, "R4 clear bit31");
        wr(2'd0, 32'h0);
        rd_chk(2'd0, 32'h3980_0000, "R4 zero write");
        wr(2'd0, 32'hFFFF_FFFF);
        rd_chk(2'd0, 32'h0, "R4 clear all");
        pulse_src(6'b010000);
        rd_chk(2'd0, 32'h0100_0000, "R2 single tx dma");
        wr(2'd0, 32'hFFFF_FFFF);
    endtask

    task automatic t_set_wins;
        pulse_src(6'b000001);
        @(negedge clk);
        src_evt = 6'b000010; reg_addr = 2'd0; reg_wdata = 32'hFFFF_FFFF; reg_wr = 1'b1;
        @(negedge clk);
        src_evt = '0; reg_wr = 1'b0; reg_wdata = '0;
        rd_chk(2'd0, 32'h2000_0000, "R5 set beats clear");
        wr(2'd0, 32'hFFFF_FFFF);
    endtask

    task automatic t_enable_irq;
        wr(2'd1, 32'hFFFF_FFFF);
        rd_chk(2'd1, 32'hBF80_0000, "R6 enable mask");
        wr(2'd2, 32'hFFFF_FFFF);
        rd_chk(2'd2, 32'h1, "R7 gie bit0");
        check("R8 irq no status", {31'b0, irq}, 32'h0);
        pulse_src(6'b100000);
        check("R8 irq asserted", {31'b0, irq}, 32'h1);
        wr(2'd2, 32'h0);
        check("R8 irq gie off", {31'b0, irq}, 32'h0);
        wr(2'd2, 32'h1);
        wr(2'd1, 32'h0100_0000);
        check("R8 irq disjoint", {31'b0, irq}, 32'h0);
        wr(2'd1, 32'h0080_0000);
        check("R8 irq overlap", {31'b0, irq}, 32'h1);
        wr(2'd0, 32'h0080_0000);
        check("R8 irq after clear", {31'b0, irq}, 32'h0);
        wr(2'd1, 32'h0);
        wr(2'd2, 32'h0);
    endtask

    task automatic t_ss;
        @(negedge clk);
        ss_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rd_chk(2'd0, 32'h0, "R3 fall not before third edge");
        @(negedge clk);
        rd_chk(2'd0, 32'h0400_0000, "R3 fall set");
        wr(2'd0, 32'h0400_0000);
        repeat (5) @(negedge clk);
        rd_chk(2'd0, 32'h0, "R10 held low no repeat");
        ss_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rd_chk(2'd0, 32'h0, "R3 rise not before third edge");
        @(negedge clk);
        rd_chk(2'd0, 32'h0200_0000, "R3 rise set");
        wr(2'd0, 32'hFFFF_FFFF);
        rd_chk(2'd0, 32'h0, "R4 ss bits cleared");
    endtask

    initial begin
        #1;
        t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reserved;
        t_sources;
        t_set_wins;
        t_enable_irq;
        t_ss;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule